// File: doc/BRIEF.md
# 1-Wire Master Time-Slot Engine

This block drives the data side of a single-wire open-drain bus as the master. It produces the three kinds of bit slot: write-0, write-1 and read. All timing is counted in cycles of a clock whose frequency is a parameter. The block only ever pulls the line low or lets it go. The external pull-up returns the line high, and the bus input is brought through a two-flop synchroniser before it is sampled.

A host can ask for a single slot. It raises `slot_req` with `slot_read` and `slot_wbit`, then waits for `slot_done`, which carries the sampled bit on `slot_rbit`. It can also hand over a whole byte to the built-in shifter, which runs eight slots least significant bit first. The shifter can send a function code such as 0xBE, 0xB4, 0x44 or 0xB8, and can then clock in the data that follows or poll for completion.

A read slot releases the line almost at once, after a 2 µs pull. The sample point sits late in the 15 µs window in which slave data is valid. This leaves the most margin for a slow pull-up rise.

The slot engine has four states:
- E_IDLE goes to E_SLOT when a request arrives.
- E_SLOT goes to E_RECOVER when the 65 µs slot count ends.
- E_RECOVER goes to E_DONE when the 2 µs recovery count ends.
- E_DONE goes back to E_IDLE after one cycle.

The byte shifter also has four states:
- B_IDLE goes to B_ISSUE when a byte is accepted.
- B_ISSUE goes to B_WAIT on the next cycle.
- B_WAIT goes back to B_ISSUE on each slot completion while bits remain.
- B_WAIT goes to B_FINISH on the eighth completion, and B_FINISH goes back to B_IDLE after one cycle.

Top module: `owm_master`

## Requirements
- R1: While `rst_n` is low and right after it, `bus_drive_low`, `busy`, `slot_done` and `byte_done` are all 0.
- R2: A write-0 slot (`slot_read`=0, `slot_wbit`=0) pulls the bus low for exactly 60 µs from the slot start, then releases it.
- R3: A write-1 slot (`slot_read`=0, `slot_wbit`=1) pulls the bus low for exactly 1 µs, then releases it, so a slave sampling at 30 µs sees a 1.
- R4: A read slot (`slot_read`=1) pulls the bus low for exactly 2 µs. It samples the synchronised bus about 13 µs after the slot start and returns low as 0 and high as 1 on `slot_rbit`.
- R5: Every slot lasts 65 µs from its falling edge. At least 2 µs of released bus follows before the next slot may begin, so consecutive falling edges are at least 67 µs apart.
- R6: `slot_done` is a single-cycle pulse in the first cycle after the 65 µs slot plus the 2 µs recovery, which is 67 µs after the falling edge.
- R7: The block never drives the bus high: its only bus output is a pull-low enable.
- R8: A byte write (`byte_req` with `byte_read`=0) sends `byte_wdata` as eight write slots, least significant bit first.
- R9: A byte read (`byte_req` with `byte_read`=1) runs eight read slots. It assembles the bits least significant first into `byte_rdata` and signals the end with a single-cycle `byte_done`.
- R10: While `busy` is 1, a new `byte_req` or `slot_req` is ignored. No extra slot is run, and the byte in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low reset |
| slot_req | input | 1 | Single-slot request (taken when not busy) |
| slot_read | input | 1 | 1 = read slot, 0 = write slot |
| slot_wbit | input | 1 | Bit value for a write slot |
| slot_done | output | 1 | One-cycle end of a host slot |
| slot_rbit | output | 1 | Bit sampled in the last read slot |
| byte_req | input | 1 | Byte transfer request (taken when not busy) |
| byte_read | input | 1 | 1 = read byte, 0 = write byte |
| byte_wdata | input | BYTE_W | Byte to send, LSB first |
| byte_done | output | 1 | One-cycle end of a byte transfer |
| byte_rdata | output | BYTE_W | Byte received, LSB first |
| busy | output | 1 | A slot or byte is in progress |
| bus_in | input | 1 | Raw bus level (asynchronous) |
| bus_drive_low | output | 1 | 1 = pull bus low, 0 = release |

## Verification
The bench targets the sample placement in a read slot. It uses a modelled slave that releases its low level at 12 µs in one slot and at 14 µs in another. A design sampling too early or too late, or one that forgot the synchroniser delay, returns the wrong bit for one of the two. Exact pull widths and the release-to-next-fall gap in back-to-back byte traffic expose a slot that is cut short or a done pulse issued before recovery. A request pushed in mid-byte shows up as an extra slot, a stray `slot_done` or a corrupted byte at the slave.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        SLOT_WR0 = 2'd0,
        SLOT_WR1 = 2'd1,
        SLOT_RD  = 2'd2
    } slot_kind_e;

    typedef enum logic [1:0] {
        E_IDLE    = 2'd0,
        E_SLOT    = 2'd1,
        E_RECOVER = 2'd2,
        E_DONE    = 2'd3
    } eng_state_e;

    typedef enum logic [1:0] {
        B_IDLE   = 2'd0,
        B_ISSUE  = 2'd1,
        B_WAIT   = 2'd2,
        B_FINISH = 2'd3
    } byte_state_e;

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
    import owm_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int W1_LOW_US = 1,
    parameter int RD_LOW_US = 2,
    parameter int SAMPLE_US = 13,
    parameter int VALID_US  = 15,
    parameter int W0_LOW_US = 60,
    parameter int SLOT_US   = 65,
    parameter int REC_US    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  slot_kind_e kind,
    input  logic       bus_sync,
    output logic       idle,
    output logic       drive_low,
    output logic       done,
    output logic       rbit
);

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int W1_CYC     = W1_LOW_US * CYC_PER_US;
    localparam int RD_CYC     = RD_LOW_US * CYC_PER_US;
    localparam int SAMPLE_CYC = SAMPLE_US * CYC_PER_US;
    localparam int VALID_CYC  = VALID_US * CYC_PER_US;
    localparam int W0_CYC     = W0_LOW_US * CYC_PER_US;
    localparam int SLOT_CYC   = SLOT_US * CYC_PER_US;
    localparam int REC_CYC    = REC_US * CYC_PER_US;
    localparam int CNT_W      = $clog2(SLOT_CYC + 1);

    localparam logic [CNT_W-1:0] W1_C      = CNT_W'(W1_CYC);
    localparam logic [CNT_W-1:0] RD_C      = CNT_W'(RD_CYC);
    localparam logic [CNT_W-1:0] W0_C      = CNT_W'(W0_CYC);
    localparam logic [CNT_W-1:0] SAMPLE_C  = CNT_W'(SAMPLE_CYC);
    localparam logic [CNT_W-1:0] VALID_C   = CNT_W'(VALID_CYC);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_CYC - 1);

    eng_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] low_q;
    slot_kind_e       kind_q;
    logic             rbit_q;
    logic             accept;
    logic             sample_en;

    function automatic logic [CNT_W-1:0] low_for(input slot_kind_e k);
        logic [CNT_W-1:0] r;
        unique case (k)
            SLOT_WR0: r = W0_C;
            SLOT_WR1: r = W1_C;
            SLOT_RD:  r = RD_C;
            default:  r = W1_C;
        endcase
        return r;
    endfunction

    assign accept    = (st_q == E_IDLE) && req;
    assign sample_en = (st_q == E_SLOT) && (kind_q == SLOT_RD) && (cnt_q == SAMPLE_C);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_IDLE:    if (req)                 st_d = E_SLOT;
            E_SLOT:    if (cnt_q == SLOT_LAST)  st_d = E_RECOVER;
            E_RECOVER: if (cnt_q == REC_LAST)   st_d = E_DONE;
            E_DONE:                             st_d = E_IDLE;
            default:                            st_d = E_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= E_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q || st_q == E_IDLE || st_q == E_DONE) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // captured request and sampled bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= SLOT_WR1;
            low_q  <= W1_C;
            rbit_q <= 1'b1;
        end else begin
            if (accept) begin
                kind_q <= kind;
                low_q  <= low_for(kind);
            end
            if (sample_en) begin
                rbit_q <= bus_sync;
            end
        end
    end

    // outputs
    always_comb begin
        idle      = (st_q == E_IDLE);
        done      = (st_q == E_DONE);
        drive_low = (st_q == E_SLOT) && (cnt_q < low_q);
        rbit      = rbit_q;
    end

    assert_sample_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (!drive_low && (cnt_q < VALID_C)));

    assert_w0_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_low) && kind_q == SLOT_WR0) |-> (cnt_q == W0_C));

    assert_slot_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> (cnt_q == '0 && $past(st_q) == E_IDLE));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_recover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st_q) == E_RECOVER && !$past(drive_low)));

endmodule

// File: rtl/owm_byte_shift.sv
module owm_byte_shift
    import owm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_req,
    input  logic              byte_read,
    input  logic [BYTE_W-1:0] byte_wdata,
    input  logic              eng_idle,
    input  logic              eng_done,
    input  logic              eng_rbit,
    output logic              slot_req,
    output slot_kind_e        slot_kind,
    output logic              busy,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_rdata
);

    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    byte_state_e       st_q, st_d;
    logic [BYTE_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic              dir_q;
    logic              start;

    assign start = (st_q == B_IDLE) && byte_req && eng_idle;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            B_IDLE:   if (start) st_d = B_ISSUE;
            B_ISSUE:             st_d = B_WAIT;
            B_WAIT:   if (eng_done) st_d = (idx_q == LAST_IDX) ? B_FINISH : B_ISSUE;
            B_FINISH:            st_d = B_IDLE;
            default:             st_d = B_IDLE;
        endcase
    end

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= B_IDLE;
            sh_q  <= '0;
            idx_q <= '0;
            dir_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start) begin
                sh_q  <= byte_wdata;
                dir_q <= byte_read;
                idx_q <= '0;
            end else if (st_q == B_WAIT && eng_done) begin
                sh_q  <= {eng_rbit, sh_q[BYTE_W-1:1]};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        slot_req   = (st_q == B_ISSUE);
        slot_kind  = dir_q ? SLOT_RD : (sh_q[0] ? SLOT_WR1 : SLOT_WR0);
        busy       = (st_q != B_IDLE);
        byte_done  = (st_q == B_FINISH);
        byte_rdata = sh_q;
    end

    assert_byte_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    assert_issue_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |-> eng_idle);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == B_WAIT && byte_req) |=> $stable(dir_q));

endmodule

// File: rtl/owm_master.sv
module owm_master
    import owm_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_req,
    input  logic              slot_read,
    input  logic              slot_wbit,
    output logic              slot_done,
    output logic              slot_rbit,
    input  logic              byte_req,
    input  logic              byte_read,
    input  logic [BYTE_W-1:0] byte_wdata,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_rdata,
    output logic              busy,
    input  logic              bus_in,
    output logic              bus_drive_low
);

    logic       bus_sync;
    logic       eng_idle, eng_done, eng_rbit, eng_req;
    slot_kind_e eng_kind, host_kind, wrap_kind;
    logic       wrap_req, wrap_busy;

    owm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (bus_sync)
    );

    assign host_kind = slot_read ? SLOT_RD : (slot_wbit ? SLOT_WR1 : SLOT_WR0);
    assign eng_req   = wrap_busy ? wrap_req : (slot_req && !byte_req);
    assign eng_kind  = wrap_busy ? wrap_kind : host_kind;

    owm_slot_engine #(.CLK_HZ(CLK_HZ)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eng_req),
        .kind      (eng_kind),
        .bus_sync  (bus_sync),
        .idle      (eng_idle),
        .drive_low (bus_drive_low),
        .done      (eng_done),
        .rbit      (eng_rbit)
    );

    owm_byte_shift #(.BYTE_W(BYTE_W)) u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_req   (byte_req),
        .byte_read  (byte_read),
        .byte_wdata (byte_wdata),
        .eng_idle   (eng_idle),
        .eng_done   (eng_done),
        .eng_rbit   (eng_rbit),
        .slot_req   (wrap_req),
        .slot_kind  (wrap_kind),
        .busy       (wrap_busy),
        .byte_done  (byte_done),
        .byte_rdata (byte_rdata)
    );

    assign slot_done = eng_done && !wrap_busy;
    assign slot_rbit = eng_rbit;
    assign busy      = wrap_busy || !eng_idle;

    assert_host_done_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !slot_done);

endmodule

// File: tb/tb_owm_master.sv
module tb_owm_master;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_req = 1'b0, slot_read = 1'b0, slot_wbit = 1'b0;
    logic          byte_req = 1'b0, byte_read = 1'b0;
    logic [BW-1:0] byte_wdata = '0;
    logic          slot_done, slot_rbit, byte_done, busy, bus_drive_low;
    logic [BW-1:0] byte_rdata;
    logic          slave_low = 1'b0;
    wire           bus_line = !(bus_drive_low || slave_low);

    always #2 clk = ~clk;   // 250 MHz

    // 4 cycles per microsecond
    owm_master #(.CLK_HZ(4_000_000), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n),
        .slot_req(slot_req), .slot_read(slot_read), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_rbit(slot_rbit),
        .byte_req(byte_req), .byte_read(byte_read), .byte_wdata(byte_wdata),
        .byte_done(byte_done), .byte_rdata(byte_rdata), .busy(busy),
        .bus_in(bus_line), .bus_drive_low(bus_drive_low)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bus monitor and slave model
    int   cyc = 0, fall_cyc = 0, rel_cyc = -1, last_fall = -1;
    int   last_len = 0, done_delay = 0, min_gap = 1 << 30, min_period = 1 << 30;
    int   slot_cnt = 0, sdone_cnt = 0, bdone_run = 0, bdone_max = 0;
    int   age = 100000, hold = 60;
    logic prev_drv = 1'b0, cur_bit = 1'b1, slave_rd_en = 1'b0;
    logic [BW-1:0] tx_sh = '1, rx_sh = '0;

    always @(negedge clk) begin
        cyc++;
        if (bus_drive_low && !prev_drv) begin
            if (last_fall >= 0 && cyc - last_fall < min_period) min_period = cyc - last_fall;
            if (rel_cyc >= 0 && cyc - rel_cyc < min_gap) min_gap = cyc - rel_cyc;
            last_fall = cyc;
            fall_cyc  = cyc;
            age       = 0;
            slot_cnt++;
            if (slave_rd_en) begin
                cur_bit = tx_sh[0];
                tx_sh   = {1'b1, tx_sh[BW-1:1]};
            end else begin
                cur_bit = 1'b1;
            end
        end else begin
            age++;
        end
        if (!bus_drive_low && prev_drv) begin
            last_len = cyc - fall_cyc;
            rel_cyc  = cyc;
        end
        slave_low = slave_rd_en && !cur_bit && (age < hold);
        if (age == 120) rx_sh = {bus_line, rx_sh[BW-1:1]};  // slave samples at 30 us
        if (slot_done) begin
            done_delay = cyc - fall_cyc;
            sdone_cnt++;
        end
        if (byte_done) bdone_run++; else bdone_run = 0;
        if (bdone_run > bdone_max) bdone_max = bdone_run;
        prev_drv = bus_drive_low;
    end

    // scoreboard
    typedef struct {
        bit            rd;
        logic [BW-1:0] val;
        string         tag;
    } exp_t;
    exp_t sbq[$];

    always @(negedge clk) begin
        if (rst_n && byte_done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R9 unexpected byte_done", 1, 0);
            end else begin
                exp_t e;
                logic [BW-1:0] act;
                e   = sbq.pop_front();
                act = e.rd ? byte_rdata : rx_sh;
                check(act == e.val, e.tag, int'(act), int'(e.val));
            end
        end
    end

    task automatic slot_op(input bit rd, input bit wb);
        @(negedge clk);
        slot_req = 1'b1; slot_read = rd; slot_wbit = wb;
        @(negedge clk);
        slot_req = 1'b0;
        while (!slot_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic byte_op(input bit rd, input logic [BW-1:0] v, input logic [BW-1:0] sv,
                           input string tag);
        exp_t e;
        e.rd = rd; e.val = rd ? sv : v; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        slave_rd_en = rd; tx_sh = sv; hold = 60;
        byte_req = 1'b1; byte_read = rd; byte_wdata = v;
        @(negedge clk);
        byte_req = 1'b0;
        while (!byte_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(bus_drive_low == 1'b0, "R1 drive in reset", int'(bus_drive_low), 0);
        check(busy == 1'b0 && slot_done == 1'b0 && byte_done == 1'b0, "R1 flags in reset",
              int'({busy, slot_done, byte_done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_drive_low == 1'b0 && busy == 1'b0, "R1 after reset",
              int'({bus_drive_low, busy}), 0);

        slot_op(1'b0, 1'b0);
        check(last_len == 240, "R2 write-0 low width", last_len, 240);
        check(rx_sh[BW-1] == 1'b0, "R2 slave saw 0", int'(rx_sh[BW-1]), 0);
        check(done_delay == 268, "R6 done after recovery", done_delay, 268);
        check(bus_line == 1'b1, "R7 bus released", int'(bus_line), 1);

        slot_op(1'b0, 1'b1);
        check(last_len == 4, "R3 write-1 low width", last_len, 4);
        check(rx_sh[BW-1] == 1'b1, "R3 slave saw 1", int'(rx_sh[BW-1]), 1);

        slave_rd_en = 1'b1; hold = 60; tx_sh = 8'hFE;
        slot_op(1'b1, 1'b0);
        check(last_len == 8, "R4 read low width", last_len, 8);
        check(slot_rbit == 1'b0, "R4 read bit 0", int'(slot_rbit), 0);
        tx_sh = 8'hFF;
        slot_op(1'b1, 1'b0);
        check(slot_rbit == 1'b1, "R4 read bit 1", int'(slot_rbit), 1);
        hold = 48; tx_sh = 8'hFE;
        slot_op(1'b1, 1'b0);
        check(slot_rbit == 1'b1, "R4 slave released at 12us", int'(slot_rbit), 1);
        hold = 56; tx_sh = 8'hFE;
        slot_op(1'b1, 1'b0);
        check(slot_rbit == 1'b0, "R4 slave held to 14us", int'(slot_rbit), 0);
        check(done_delay == 268, "R6 read done timing", done_delay, 268);
        slave_rd_en = 1'b0; hold = 60;

        begin
            int s0;
            s0 = slot_cnt;
            min_gap = 1 << 30; min_period = 1 << 30; last_fall = -1; rel_cyc = -1;
            byte_op(1'b0, 8'hBE, 8'hFF, "R8 write 0xBE");
            check(slot_cnt - s0 == 8, "R8 eight slots", slot_cnt - s0, 8);
            check(min_period >= 268, "R5 slot period", min_period, 268);
            check(min_gap >= 8, "R5 recovery gap", min_gap, 8);
        end
        byte_op(1'b1, 8'h00, 8'h5A, "R9 read 0x5A");
        byte_op(1'b0, 8'hB4, 8'hFF, "R8 write 0xB4");
        byte_op(1'b1, 8'h00, 8'hA5, "R9 read 0xA5");
        byte_op(1'b0, 8'h01, 8'hFF, "R8 write 0x01");
        check(min_period >= 268, "R5 period over bytes", min_period, 268);
        check(bdone_max == 1, "R9 byte_done one cycle", bdone_max, 1);

        begin
            int s0, d0;
            exp_t e;
            e.rd = 1'b0; e.val = 8'h44; e.tag = "R10 byte kept under new request";
            sbq.push_back(e);
            s0 = slot_cnt; d0 = sdone_cnt;
            @(negedge clk);
            byte_req = 1'b1; byte_read = 1'b0; byte_wdata = 8'h44;
            @(negedge clk);
            byte_req = 1'b0;
            repeat (100) @(negedge clk);
            check(busy == 1'b1, "R10 busy mid-byte", int'(busy), 1);
            byte_req = 1'b1; byte_read = 1'b1; byte_wdata = 8'hFF;
            slot_req = 1'b1; slot_read = 1'b0; slot_wbit = 1'b0;
            @(negedge clk);
            byte_req = 1'b0; slot_req = 1'b0;
            while (!byte_done) @(negedge clk);
            repeat (600) @(negedge clk);
            check(slot_cnt - s0 == 8, "R10 no extra slot", slot_cnt - s0, 8);
            check(sdone_cnt == d0, "R10 no host done", sdone_cnt - d0, 0);
            check(busy == 1'b0, "R10 idle after byte", int'(busy), 0);
        end

        check(sbq.size() == 0, "R9 scoreboard drained", sbq.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule